// File: doc/BRIEF.md
# Two-Wire Slave Port for a Three-Channel Resistor Register Bank

This block is a two-wire (I2C) slave that runs entirely on a system clock. It samples the bus clock and data lines through a synchroniser, detects start and stop conditions, and drives the data line only through an open-drain pull-down enable. It gives a host access to three 8-bit resistor control registers. In each register, bit 7 is a high-impedance control bit and bits 6:0 select one of 128 wiper positions. The three registers are exported as parallel outputs for the analog channels.

A write is a single transaction with three bytes: the device address with the direction bit low, a register address, and exactly one data byte. The transaction is closed by a stop. That stop starts a timed busy period, which stands in for the nonvolatile write cycle. While the busy period runs, the port ignores the bus completely and does not acknowledge its own address. A host can therefore poll with address-only transactions until it gets an acknowledge. The register changes when the busy period ends.

A read starts with a dummy write that loads the register pointer. The host then sends a repeated start, the device address with the direction bit high, receives one byte, answers with a NACK and sends a stop. The device address is a fixed prefix followed by strap pins. The default build uses six prefix bits and one strap pin. A build with three strap pins uses a four-bit prefix.

Top module: `rheo_regport`

## Requirements
- R1: While reset is high and after it is released, the SDA pull-down enable is low. All three channel outputs hold REG_DEFAULT.
- R2: The address byte is received MSB first. It is acknowledged only when its upper seven bits equal the prefix 101000 followed by the strap pin, and the acknowledge comes with the direction bit in bit 0. The acknowledge is SDA held low for the ninth SCL clock of the byte. A byte with a different prefix bit or a different strap value gets no acknowledge.
- R3: A write is made of the address byte with bit 0 = 0, a register address and one data byte, and each byte is acknowledged. If it ends in a stop, all 8 data bits land in the register at F8h, F9h or FAh. These addresses map to channel outputs 0, 1 and 2.
- R4: After a stop ends a write, the port acknowledges nothing for BUSY_CYCLES system clocks, and during that time no channel output changes. Once the period has elapsed, the address is acknowledged again and the channel shows the new value.
- R5: A read is a dummy write of the register address, a repeated start, and the address byte with bit 0 = 1. It returns the register contents MSB first, on SDA while SCL is high.
- R6: A write to a register address outside F8h to FAh has all of its bytes acknowledged but changes no channel. A read from such an address returns 00h.
- R7: Any start condition aborts a partly received transaction, and a write that a start cuts off before its stop is never committed. After up to nine SCL cycles with SDA released, a fresh start begins a normal transaction.
- R8: A transaction that stops after the address byte or after the register address starts no busy period. The next address byte is acknowledged at once.
- R9: After an address mismatch, the port stays idle until the next start. It acknowledges none of the following bytes, and those bytes change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired level) |
| strap_i | input | STRAP_BITS | Hard-wired low address bits |
| sda_oe_o | output | 1 | Pull SDA low when high; release when low |
| chan0_q | output | 8 | Register F8h: bit 7 high-impedance control, bits 6:0 position |
| chan1_q | output | 8 | Register F9h, same layout |
| chan2_q | output | 8 | Register FAh, same layout |

## Verification
The bench sets BUSY_CYCLES to 300 system clocks and uses a bus bit time of 24 system clocks. With these values, the first address poll after a write is refused, a later poll is accepted, and the bench observes the register update at the end of the busy period. It keeps REG_DEFAULT at 40h, which differs from every written pattern, so the reset values and any missed commit are visible. It uses STRAP_BITS = 1 and changes the strap pin during the run, so that both strap values and a byte with a wrong prefix bit are exercised.

// File: rtl/rheo_pkg.sv
package rheo_pkg;
  localparam int CH_COUNT = 3;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_DEV_ACK,
    ST_REG,
    ST_REG_ACK,
    ST_DAT,
    ST_DAT_ACK,
    ST_WAIT_STOP,
    ST_TX,
    ST_TX_ACK
  } port_state_t;
endpackage

// File: rtl/rheo_line_sync.sv
module rheo_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_q;
      sda_d    <= sda_q;
    end
  end

  assign scl_q     = scl_pipe[STAGES-1];
  assign sda_q     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_q & ~scl_d;
  assign scl_fall  = ~scl_q & scl_d;
  assign start_det = scl_q & scl_d & sda_d & ~sda_q;
  assign stop_det  = scl_q & scl_d & ~sda_d & sda_q;
endmodule

// File: rtl/rheo_busy_timer.sv
module rheo_busy_timer #(
  parameter int unsigned CYCLES = 20000
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic busy,
  output logic done
);
  localparam int W = $clog2(CYCLES + 1);
  logic [W-1:0] left;

  always_ff @(posedge clk) begin
    if (rst)              left <= '0;
    else if (kick)        left <= W'(CYCLES);
    else if (left != '0)  left <= left - 1'b1;
  end

  assign busy = (left != '0);
  assign done = (left == W'(1));
endmodule

// File: rtl/rheo_regbank.sv
module rheo_regbank #(
  parameter int         N       = 3,
  parameter logic [7:0] BASE    = 8'hF8,
  parameter logic [7:0] DEFAULT = 8'h40
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [7:0]       rd_addr,
  output logic [7:0]       rd_data,
  output logic [N-1:0][7:0] regs_q
);
  for (genvar g = 0; g < N; g++) begin : g_cell
    always_ff @(posedge clk) begin
      if (rst)
        regs_q[g] <= DEFAULT;
      else if (wr_en && wr_addr == 8'(int'(BASE) + g))
        regs_q[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < N; i++)
      if (rd_addr == 8'(int'(BASE) + i)) rd_data = regs_q[i];
  end
endmodule

// File: rtl/rheo_regport.sv
module rheo_regport #(
  parameter int          STRAP_BITS  = 1,
  parameter logic [6:0]  DEV_PREFIX  = 7'b1010000,
  parameter logic [7:0]  REG_BASE    = 8'hF8,
  parameter logic [7:0]  REG_DEFAULT = 8'h40,
  parameter int unsigned BUSY_CYCLES = 20000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_i,
  input  logic                  sda_i,
  input  logic [STRAP_BITS-1:0] strap_i,
  output logic                  sda_oe_o,
  output logic [7:0]            chan0_q,
  output logic [7:0]            chan1_q,
  output logic [7:0]            chan2_q
);
  import rheo_pkg::*;

  localparam logic [6:0] STRAP_MASK = 7'((1 << STRAP_BITS) - 1);

  logic sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic busy, commit, kick, wait_stop;
  port_state_t state;
  logic [3:0] bit_cnt;
  logic [7:0] shreg, reg_ptr, pend_addr, pend_data, rd_data;
  logic       rw_bit;
  logic [CH_COUNT-1:0][7:0] regs;
  logic       dev_match;

  rheo_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  rheo_busy_timer #(.CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .kick(kick), .busy(busy), .done(commit)
  );

  rheo_regbank #(.N(CH_COUNT), .BASE(REG_BASE), .DEFAULT(REG_DEFAULT)) u_bank (
    .clk(clk), .rst(rst), .wr_en(commit), .wr_addr(pend_addr),
    .wr_data(pend_data), .rd_addr(reg_ptr), .rd_data(rd_data), .regs_q(regs)
  );

  assign wait_stop = (state == ST_WAIT_STOP);
  assign kick      = !busy && stop_det && wait_stop;
  assign dev_match = ((shreg[7:1] & ~STRAP_MASK) == (DEV_PREFIX & ~STRAP_MASK)) &&
                     ((shreg[7:1] & STRAP_MASK) == 7'(strap_i));

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bit_cnt   <= '0;
      shreg     <= '0;
      reg_ptr   <= '0;
      pend_addr <= '0;
      pend_data <= '0;
      rw_bit    <= 1'b0;
      sda_oe_o  <= 1'b0;
    end else if (busy) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      sda_oe_o <= 1'b0;
    end else if (start_det) begin
      state    <= ST_DEV;
      bit_cnt  <= '0;
      sda_oe_o <= 1'b0;
    end else if (stop_det) begin
      state    <= ST_IDLE;
      sda_oe_o <= 1'b0;
    end else begin
      case (state)
        ST_DEV, ST_REG, ST_DAT: begin
          if (scl_rise && bit_cnt < 4'd8) begin
            shreg   <= {shreg[6:0], sda_q};
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall && bit_cnt == 4'd8) begin
            if (state == ST_DEV) begin
              if (dev_match) begin
                sda_oe_o <= 1'b1;
                rw_bit   <= shreg[0];
                state    <= ST_DEV_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else if (state == ST_REG) begin
              sda_oe_o <= 1'b1;
              reg_ptr  <= shreg;
              state    <= ST_REG_ACK;
            end else begin
              sda_oe_o  <= 1'b1;
              pend_addr <= reg_ptr;
              pend_data <= shreg;
              state     <= ST_DAT_ACK;
            end
          end
        end
        ST_DEV_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rw_bit) begin
              shreg    <= rd_data;
              sda_oe_o <= ~rd_data[7];
              state    <= ST_TX;
            end else begin
              sda_oe_o <= 1'b0;
              state    <= ST_REG;
            end
          end
        end
        ST_REG_ACK: begin
          if (scl_fall) begin
            sda_oe_o <= 1'b0;
            bit_cnt  <= '0;
            state    <= ST_DAT;
          end
        end
        ST_DAT_ACK: begin
          if (scl_fall) begin
            sda_oe_o <= 1'b0;
            state    <= ST_WAIT_STOP;
          end
        end
        ST_TX: begin
          if (scl_rise && bit_cnt < 4'd8) begin
            bit_cnt <= bit_cnt + 1'b1;
          end else if (scl_fall) begin
            if (bit_cnt == 4'd8) begin
              sda_oe_o <= 1'b0;
              state    <= ST_TX_ACK;
            end else begin
              shreg    <= {shreg[6:0], 1'b0};
              sda_oe_o <= ~shreg[6];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) state <= ST_IDLE;
        end
        default: ;
      endcase
    end
  end

  assign chan0_q = regs[0];
  assign chan1_q = regs[1];
  assign chan2_q = regs[2];
endmodule

// File: rtl/rheo_port_checker.sv
module rheo_port_checker (
  input logic        clk,
  input logic        rst,
  input logic        sda_oe,
  input logic        scl_fall,
  input logic        busy,
  input logic        commit,
  input logic        stop_det,
  input logic        wait_stop,
  input logic [23:0] chans
);
  p_quiet_after_reset_r1: assert property (@(posedge clk) rst |=> !sda_oe)
    else $error("R1: SDA driven after reset");

  p_ack_after_fall_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(scl_fall))
    else $error("R2: SDA pull-down began outside SCL low phase");

  p_commit_ends_busy_r3: assert property (@(posedge clk) disable iff (rst)
    commit |=> !busy)
    else $error("R3: busy outlived the commit");

  p_no_ack_busy_r4: assert property (@(posedge clk) disable iff (rst)
    busy |-> !sda_oe)
    else $error("R4: SDA driven while busy");

  p_regs_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(chans))
    else $error("R4: channel changed without a commit");

  p_stop_starts_busy_r4: assert property (@(posedge clk) disable iff (rst)
    (stop_det && wait_stop && !busy) |=> busy)
    else $error("R4: write stop did not start busy period");
endmodule

bind rheo_regport rheo_port_checker u_chk (
  .clk(clk), .rst(rst), .sda_oe(sda_oe_o), .scl_fall(scl_fall),
  .busy(busy), .commit(commit), .stop_det(stop_det), .wait_stop(wait_stop),
  .chans({chan2_q, chan1_q, chan0_q})
);

// File: tb/rheo_regport_bench.sv
`timescale 1ns/1ps
module rheo_regport_bench;
  localparam int          Q    = 6;
  localparam int unsigned BUSY = 300;
  localparam logic [7:0]  DEF  = 8'h40;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [0:0] strap = 1'b0;
  logic sda_oe;
  logic [7:0] c0, c1, c2;
  wire  sda_bus = sda_m & ~sda_oe;

  int checks = 0, fails = 0;
  logic [7:0] model [3];

  always #2.5 clk = ~clk;

  rheo_regport #(.BUSY_CYCLES(BUSY), .REG_DEFAULT(DEF)) u_rheo_regport (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .strap_i(strap),
    .sda_oe_o(sda_oe), .chan0_q(c0), .chan1_q(c1), .chan2_q(c2)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a >= 8'hF8 && a <= 8'hFA) return model[a - 8'hF8];
    return 8'h00;
  endfunction

  function automatic logic [7:0] dev(input logic a0, input logic rw);
    return {6'b101000, a0, rw};
  endfunction

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic xbit(input logic b, output logic r);
    sda_m = b; wq(); scl_m = 1'b1; wq(); r = sda_bus; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bstart();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bstop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic sendb(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) xbit(b[i], r);
    xbit(1'b1, r);
    ack = !r;
  endtask

  task automatic recvb(output logic [7:0] d);
    logic r;
    for (int i = 7; i >= 0; i--) begin xbit(1'b1, r); d[i] = r; end
    xbit(1'b1, r);
  endtask

  task automatic wr(input logic a0, input logic [7:0] ra, input logic [7:0] d,
                    output logic [2:0] acks);
    bstart();
    sendb(dev(a0, 1'b0), acks[2]);
    sendb(ra, acks[1]);
    sendb(d, acks[0]);
    bstop();
  endtask

  task automatic rd(input logic [7:0] ra, output logic [7:0] d, output logic [2:0] acks);
    bstart();
    sendb(dev(strap[0], 1'b0), acks[2]);
    sendb(ra, acks[1]);
    bstart();
    sendb(dev(strap[0], 1'b1), acks[0]);
    recvb(d);
    bstop();
  endtask

  task automatic poll(output logic ack);
    bstart(); sendb(dev(strap[0], 1'b0), ack); bstop();
  endtask

  task automatic wait_ready(output int tries);
    logic a;
    tries = 0;
    do begin poll(a); tries++; end while (!a && tries < 12);
  endtask

  task automatic chk_chans(input string req);
    chk(req, c0, model[0]); chk(req, c1, model[1]); chk(req, c2, model[2]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [2:0] acks;
    logic [7:0] d;
    logic a;
    int tries;
    void'($urandom(32'h1f2e3d4c));
    for (int i = 0; i < 3; i++) model[i] = DEF;
    scl_m = 1'b0;
    repeat (10) @(negedge clk);
    chk("R1 oe in reset", sda_oe, 0);
    rst = 1'b0;
    scl_m = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 oe after reset", sda_oe, 0);
    chk_chans("R1 defaults");

    rd(8'hF9, d, acks);
    chk("R5 read acks", acks, 3'b111);
    chk("R5 read default", d, DEF);

    // R3/R4 directed write with bit 7 set
    wr(1'b0, 8'hF8, 8'h95, acks);
    chk("R3 write acks", acks, 3'b111);
    chk("R4 no early update", c0, DEF);
    poll(a);
    chk("R4 first poll refused", a, 0);
    chk("R4 held while busy", c0, DEF);
    wait_ready(tries);
    chk("R4 ready after busy", tries < 12, 1);
    model[0] = 8'h95;
    chk_chans("R3 committed");
    rd(8'hF8, d, acks);
    chk("R5 readback", d, 8'h95);

    // R2 mismatches, R9 ignore rest
    bstart();
    sendb(dev(1'b1, 1'b0), a);
    chk("R2 strap mismatch nack", a, 0);
    sendb(8'hFA, a);
    chk("R9 reg byte ignored", a, 0);
    sendb(8'h11, a);
    chk("R9 data byte ignored", a, 0);
    bstop();
    poll(a);
    chk("R9 no busy after mismatch", a, 1);
    chk_chans("R9 regs unchanged");
    bstart();
    sendb(8'b1011_0000, a);
    chk("R2 prefix mismatch nack", a, 0);
    bstop();

    // R6 out of range
    wr(1'b0, 8'h10, 8'hAA, acks);
    chk("R6 out of range acks", acks, 3'b111);
    wait_ready(tries);
    chk_chans("R6 discarded");
    rd(8'h10, d, acks);
    chk("R6 read low out of range", d, 8'h00);
    rd(8'hFB, d, acks);
    chk("R6 read FBh", d, 8'h00);

    // R8 dummy write then immediate ack
    bstart(); sendb(dev(1'b0, 1'b0), a); sendb(8'hF9, a); bstop();
    poll(a);
    chk("R8 no busy after reg-only", a, 1);

    // R7 start aborts mid-byte
    bstart(); sendb(dev(1'b0, 1'b0), a);
    for (int i = 0; i < 4; i++) xbit(1'b1, a);
    wr(1'b0, 8'hF9, 8'h21, acks);
    chk("R7 write after abort acks", acks, 3'b111);
    wait_ready(tries);
    model[1] = 8'h21;
    chk_chans("R7 write after abort");

    // R7 repeated start replaces stop: no commit
    bstart(); sendb(dev(1'b0, 1'b0), a); sendb(8'hFA, a); sendb(8'h77, a);
    bstart(); bstop();
    poll(a);
    chk("R7 uncommitted write not busy", a, 1);
    chk_chans("R7 uncommitted write");

    // R7 nine released clocks during a read, then fresh start
    bstart(); sendb(dev(1'b0, 1'b1), a);
    for (int i = 0; i < 9; i++) xbit(1'b1, a);
    rd(8'hF9, d, acks);
    chk("R7 recovery read", d, 8'h21);

    // R2 strap value 1
    strap = 1'b1;
    wr(1'b1, 8'hFA, 8'h3C, acks);
    chk("R2 strap one acks", acks, 3'b111);
    wait_ready(tries);
    model[2] = 8'h3C;
    chk_chans("R2 strap one write");
    bstart(); sendb(dev(1'b0, 1'b0), a); bstop();
    chk("R2 old strap refused", a, 0);
    strap = 1'b0;

    // random writes and reads
    for (int n = 0; n < 12; n++) begin
      logic [7:0] ra, dv;
      int sel;
      sel = $urandom_range(0, 3);
      ra = (sel == 3) ? 8'($urandom_range(0, 247)) : 8'(8'hF8 + sel);
      dv = 8'($urandom);
      wr(1'b0, ra, dv, acks);
      chk("R3 random write acks", acks, 3'b111);
      wait_ready(tries);
      if (sel != 3) model[sel] = dv;
      chk_chans("R3 random commit");
      ra = 8'(8'hF8 + $urandom_range(0, 3));
      rd(ra, d, acks);
      chk("R5 random read", d, exp_rd(ra));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule